// File: doc/BRIEF.md
# Wake Line Driver Controller

This block governs one end of an active-high wake line that several nodes share. In output mode, software sets a request bit. After a fixed settling delay, the block raises a driver-enable signal toward an external high-side switch. A one-shot timer ends the drive on its own after a long interval unless software turns that timer off.

While the line is being driven, a short-circuit comparator output is watched. Only a trip that persists without a break for a set time is recorded. A thermal fault cuts the drive at once and holds it off until software re-arms the block. In input mode the driver stays off and each change of the synchronized pin level is flagged. Flags are sticky and can be routed to one interrupt line.

All intervals are given in clock cycles and derive by default from a clock-rate parameter: 10 us settling, 400 us short persistence, 1.3 s timeout. Registers: address 0 control (bit0 drive request, bit1 timeout off, bit2 input mode), address 1 interrupt enables (bit0 short, bit1 edge), address 2 status (bit0 short, bit1 edge, bit2 thermal latch, bit3 timeout expired, bit7 pin level), address 3 command (bit0 thermal re-arm, write only, reads 0).

Top module: `wake_line_ctrl`

## Requirements
- R1: After reset `wake_drv_en` and `irq` are 0, and the control, enable and status registers read 0 apart from the pin level in status bit7.
- R2: Writing control bit0 changes `wake_drv_en` exactly LAT_CYCLES+1 clock edges after the write edge, for both rising and falling requests.
- R3: With control bit1 at 0, `wake_drv_en` stays high for exactly TMO_CYCLES clocks and then falls although bit0 is still 1. Status bit3 then reads 1.
- R4: With control bit1 at 1, the drive stays high for as long as bit0 is 1, and status bit3 reads 0.
- R5: Status bit0 is set only when `sc_trip` has been high for at least SC_CYCLES consecutive clocks while `wake_drv_en` is high. Shorter pulses, and pulses while the driver is off, leave it clear.
- R6: `therm_fault` high forces `wake_drv_en` low at the next clock edge and sets status bit2. The drive stays off after the fault clears, until address 3 bit0 is written with 1 while `therm_fault` is low.
- R7: With control bit2 at 1, `wake_drv_en` is 0, and every rising or falling edge of the synchronized pin sets status bit1.
- R8: Status bit7 shows `wake_pin_in` through a two-flop synchronizer in both modes.
- R9: Writing 1 to status bit0 or bit1 clears that bit. Writing 0 leaves it unchanged.
- R10: `irq` is the registered OR of status bits 0 and 1, each gated by the matching enable bit at address 1.
- R11: In output mode, pin edges do not set status bit1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 8 | Registered read data, valid one clock after rd_addr |
| sc_trip | input | 1 | Asynchronous short-circuit comparator output |
| therm_fault | input | 1 | Synchronous thermal shutdown indication |
| wake_pin_in | input | 1 | Asynchronous level of the external wake line |
| wake_drv_en | output | 1 | Enable for the high-side line driver |
| irq | output | 1 | Interrupt request |

## Verification
On every cycle, the assertions check the following. A thermal fault or input mode leaves the driver off on the next edge. The delayed request moves only while it differs from the written request. An expired timeout turns the driver off. The short qualifier fires as a single pulse. The edge flag is never set while the block is in output mode. The interrupt is only raised after a pending flag.

The exact settling delay, the exact timeout length and the persistence threshold are observable only through the bench's scenarios. The same holds for write-one-to-clear and the thermal re-arm sequence. The bench sweeps short pulse lengths across the threshold and a run of pin toggles in both modes, computing each expected value from the cycle counts.

// File: rtl/wake_pkg.sv
package wake_pkg;
  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_IEN  = 2'd1;
  localparam logic [1:0] ADDR_STAT = 2'd2;
  localparam logic [1:0] ADDR_CMD  = 2'd3;

  typedef struct packed {
    logic io_mode;
    logic tmo_off;
    logic drive_req;
  } ctrl_t;

  typedef struct packed {
    logic edge_ie;
    logic sc_ie;
  } ien_t;
endpackage

// File: rtl/wake_sync.sv
module wake_sync #(
  parameter int unsigned WIDTH  = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stage_q[0] <= '0;
          else     stage_q[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stage_q[s] <= '0;
          else     stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/wake_persist.sv
module wake_persist #(
  parameter int unsigned LIMIT = 8192
) (
  input  logic clk,
  input  logic rst,
  input  logic arm,
  input  logic level,
  output logic fire
);
  localparam int unsigned CW = (LIMIT < 2) ? 1 : $clog2(LIMIT);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] run_cnt;
  logic          done;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_cnt <= '0;
      done    <= 1'b0;
      fire    <= 1'b0;
    end else begin
      fire <= 1'b0;
      if (arm && level) begin
        if (!done) begin
          if (run_cnt == LAST) begin
            fire <= 1'b1;
            done <= 1'b1;
          end else begin
            run_cnt <= run_cnt + 1'b1;
          end
        end
      end else begin
        run_cnt <= '0;
        done    <= 1'b0;
      end
    end
  end

  a_r5_single_pulse: assert property (@(posedge clk) disable iff (rst)
    fire |=> !fire);
endmodule

// File: rtl/wake_drive_timer.sv
module wake_drive_timer #(
  parameter int unsigned LAT_CYCLES = 204,
  parameter int unsigned TMO_CYCLES = 26_624_000
) (
  input  logic clk,
  input  logic rst,
  input  logic req,
  input  logic tmo_off,
  input  logic inhibit,
  output logic drv_en,
  output logic tmo_hit
);
  localparam int unsigned LW = (LAT_CYCLES < 2) ? 1 : $clog2(LAT_CYCLES);
  localparam int unsigned TW = (TMO_CYCLES < 2) ? 1 : $clog2(TMO_CYCLES);
  localparam logic [LW-1:0] LAT_LAST = LW'(LAT_CYCLES - 1);
  localparam logic [TW-1:0] TMO_LAST = TW'(TMO_CYCLES - 1);

  logic          req_dly;
  logic [LW-1:0] lat_cnt;
  logic [TW-1:0] tmo_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      req_dly <= 1'b0;
      lat_cnt <= '0;
    end else if (req != req_dly) begin
      if (lat_cnt == LAT_LAST) begin
        req_dly <= req;
        lat_cnt <= '0;
      end else begin
        lat_cnt <= lat_cnt + 1'b1;
      end
    end else begin
      lat_cnt <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tmo_cnt <= '0;
      tmo_hit <= 1'b0;
    end else if (!req_dly || inhibit || tmo_off) begin
      tmo_cnt <= '0;
      tmo_hit <= 1'b0;
    end else if (!tmo_hit) begin
      if (tmo_cnt == TMO_LAST) tmo_hit <= 1'b1;
      else                     tmo_cnt <= tmo_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) drv_en <= 1'b0;
    else     drv_en <= req_dly && !inhibit && !tmo_hit;
  end

  a_r2_delay_holds: assert property (@(posedge clk) disable iff (rst)
    (req == req_dly) |=> $stable(req_dly));
  a_r3_timeout_cuts: assert property (@(posedge clk) disable iff (rst)
    (tmo_hit && !tmo_off && req_dly) |=> !drv_en);
endmodule

// File: rtl/wake_line_ctrl.sv
module wake_line_ctrl
  import wake_pkg::*;
#(
  parameter int unsigned CLK_HZ     = 20_480_000,
  parameter int unsigned LAT_CYCLES = CLK_HZ / 100_000,
  parameter int unsigned SC_CYCLES  = CLK_HZ / 2_500,
  parameter int unsigned TMO_CYCLES = (CLK_HZ / 10) * 13
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_en,
  input  logic [1:0] wr_addr,
  input  logic [7:0] wr_data,
  input  logic [1:0] rd_addr,
  output logic [7:0] rd_data,
  input  logic       sc_trip,
  input  logic       therm_fault,
  input  logic       wake_pin_in,
  output logic       wake_drv_en,
  output logic       irq
);
  ctrl_t ctrl;
  ien_t  ien;
  logic  sc_flag, edge_flag, therm_lat, tmo_hit;
  logic  sc_s, pin_s, pin_q, sc_fire, inhibit;
  logic  wr_ctrl, wr_ien, wr_stat, rearm;
  logic  wr_hi_unused;

  assign wr_ctrl = wr_en && (wr_addr == ADDR_CTRL);
  assign wr_ien  = wr_en && (wr_addr == ADDR_IEN);
  assign wr_stat = wr_en && (wr_addr == ADDR_STAT);
  assign rearm   = wr_en && (wr_addr == ADDR_CMD) && wr_data[0];
  assign wr_hi_unused = ^wr_data[7:4];

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl <= '0;
      ien  <= '0;
    end else begin
      if (wr_ctrl) ctrl <= ctrl_t'(wr_data[2:0]);
      if (wr_ien)  ien  <= ien_t'(wr_data[1:0]);
    end
  end

  wake_sync #(.WIDTH(2), .STAGES(2)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({sc_trip, wake_pin_in}),
    .q   ({sc_s, pin_s})
  );

  always_ff @(posedge clk) begin
    if (rst) pin_q <= 1'b0;
    else     pin_q <= pin_s;
  end

  assign inhibit = ctrl.io_mode || therm_fault || therm_lat;

  wake_drive_timer #(.LAT_CYCLES(LAT_CYCLES), .TMO_CYCLES(TMO_CYCLES)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .req     (ctrl.drive_req),
    .tmo_off (ctrl.tmo_off),
    .inhibit (inhibit),
    .drv_en  (wake_drv_en),
    .tmo_hit (tmo_hit)
  );

  wake_persist #(.LIMIT(SC_CYCLES)) u_sc_filter (
    .clk   (clk),
    .rst   (rst),
    .arm   (wake_drv_en),
    .level (sc_s),
    .fire  (sc_fire)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sc_flag   <= 1'b0;
      edge_flag <= 1'b0;
      therm_lat <= 1'b0;
    end else begin
      sc_flag   <= (sc_flag && !(wr_stat && wr_data[0])) || sc_fire;
      edge_flag <= (edge_flag && !(wr_stat && wr_data[1])) ||
                   (ctrl.io_mode && (pin_s != pin_q));
      therm_lat <= therm_fault || (therm_lat && !rearm);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= (sc_flag && ien.sc_ie) || (edge_flag && ien.edge_ie);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else begin
      unique case (rd_addr)
        ADDR_CTRL: rd_data <= {5'd0, ctrl};
        ADDR_IEN:  rd_data <= {6'd0, ien};
        ADDR_STAT: rd_data <= {pin_s, 3'd0, tmo_hit, therm_lat, edge_flag, sc_flag};
        default:   rd_data <= '0;
      endcase
    end
  end

  a_r6_thermal_cut: assert property (@(posedge clk) disable iff (rst)
    therm_fault |=> !wake_drv_en);
  a_r7_input_mode_off: assert property (@(posedge clk) disable iff (rst)
    ctrl.io_mode |=> !wake_drv_en);
  a_r10_irq_source: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(sc_flag || edge_flag));
  a_r11_no_edge_in_output: assert property (@(posedge clk) disable iff (rst)
    (!ctrl.io_mode && !edge_flag) |=> !edge_flag);
endmodule

// File: tb/wake_line_ctrl_bench.sv
module wake_line_ctrl_bench;
  localparam int LAT = 4;
  localparam int SC  = 6;
  localparam int TMO = 20;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [1:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic       sc_trip = 1'b0;
  logic       therm_fault = 1'b0;
  logic       wake_pin_in = 1'b0;
  logic       wake_drv_en;
  logic       irq;

  int nchk = 0;
  int nfail = 0;
  bit finished = 1'b0;
  logic [7:0] rdv;

  always #4 clk = ~clk;

  wake_line_ctrl #(.LAT_CYCLES(LAT), .SC_CYCLES(SC), .TMO_CYCLES(TMO)) u_wake_line_ctrl (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .sc_trip(sc_trip),
    .therm_fault(therm_fault), .wake_pin_in(wake_pin_in),
    .wake_drv_en(wake_drv_en), .irq(irq)
  );

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a);
    @(negedge clk);
    rd_addr = a;
    @(negedge clk);
    rdv = rd_data;
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      nfail++;
      nchk++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end

  initial begin
    int n;
    wait_n(4);
    rst = 1'b0;
    wait_n(1);
    // R1 reset state
    chk("R1 drv", wake_drv_en, 0);
    chk("R1 irq", irq, 0);
    rd(2'd0); chk("R1 ctrl", rdv, 0);
    rd(2'd1); chk("R1 ien", rdv, 0);
    rd(2'd2); chk("R1 stat", rdv, 0);

    // R2 rising latency, R3 timeout length
    wr(2'd0, 8'h01);
    wait_n(LAT); chk("R2 before", wake_drv_en, 0);
    wait_n(1);   chk("R2 rise", wake_drv_en, 1);
    n = 1;
    while (wake_drv_en && n < TMO + 10) begin
      @(negedge clk);
      if (wake_drv_en) n++;
    end
    chk("R3 high cycles", n, TMO);
    rd(2'd2); chk("R3 expired bit", (rdv >> 3) & 1, 1);
    wr(2'd0, 8'h00);
    wait_n(LAT + 3);
    rd(2'd2); chk("R3 expired clears", (rdv >> 3) & 1, 0);

    // R4 timeout disabled
    wr(2'd0, 8'h03);
    wait_n(LAT); chk("R2 before b", wake_drv_en, 0);
    wait_n(1);   chk("R2 rise b", wake_drv_en, 1);
    wait_n(3 * TMO);
    chk("R4 still on", wake_drv_en, 1);
    rd(2'd2); chk("R4 no expiry", (rdv >> 3) & 1, 0);

    // R2 falling latency
    wr(2'd0, 8'h02);
    wait_n(LAT); chk("R2 fall before", wake_drv_en, 1);
    wait_n(1);   chk("R2 fall", wake_drv_en, 0);
    wr(2'd0, 8'h03);
    wait_n(LAT + 2);
    chk("R4 on again", wake_drv_en, 1);

    // R5 sweep of pulse lengths across the threshold, R10 irq, R9 clear
    wr(2'd1, 8'h01);
    for (int len = 1; len <= SC + 2; len++) begin
      wr(2'd2, 8'h03);
      @(negedge clk); sc_trip = 1'b1;
      wait_n(len);
      sc_trip = 1'b0;
      wait_n(5);
      rd(2'd2);
      chk("R5 short flag", rdv & 1, (len >= SC) ? 1 : 0);
      chk("R10 irq short", irq, (len >= SC) ? 1 : 0);
    end
    wr(2'd2, 8'h00);
    wait_n(2);
    rd(2'd2); chk("R9 zero write keeps", rdv & 1, 1);
    wr(2'd2, 8'h01);
    wait_n(2);
    rd(2'd2); chk("R9 one write clears", rdv & 1, 0);
    chk("R10 irq drops", irq, 0);

    // R5 pulse while driver off
    wr(2'd0, 8'h02);
    wait_n(LAT + 3);
    chk("R5 drv off", wake_drv_en, 0);
    @(negedge clk); sc_trip = 1'b1;
    wait_n(SC + 3);
    sc_trip = 1'b0;
    wait_n(4);
    rd(2'd2); chk("R5 no flag when off", rdv & 1, 0);

    // R6 thermal latch and re-arm
    wr(2'd0, 8'h03);
    wait_n(LAT + 3);
    chk("R6 driving", wake_drv_en, 1);
    therm_fault = 1'b1;
    wait_n(1); chk("R6 cut next edge", wake_drv_en, 0);
    rd(2'd2); chk("R6 latch bit", (rdv >> 2) & 1, 1);
    wr(2'd3, 8'h01);
    wait_n(3); chk("R6 rearm ignored in fault", wake_drv_en, 0);
    therm_fault = 1'b0;
    wait_n(5); chk("R6 stays off", wake_drv_en, 0);
    wr(2'd3, 8'h01);
    wait_n(1); chk("R6 rearmed", wake_drv_en, 1);
    rd(2'd2); chk("R6 latch clear", (rdv >> 2) & 1, 0);

    // R8 and R11 in output mode
    wr(2'd1, 8'h02);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); wake_pin_in = ~wake_pin_in;
      wait_n(4);
      rd(2'd2);
      chk("R8 level out", (rdv >> 7) & 1, int'(wake_pin_in));
      chk("R11 no edge out", (rdv >> 1) & 1, 0);
    end

    // R7 input mode edges
    wr(2'd0, 8'h06);
    wait_n(1); chk("R7 drv off", wake_drv_en, 0);
    for (int i = 0; i < 6; i++) begin
      wr(2'd2, 8'h02);
      wait_n(1);
      @(negedge clk); wake_pin_in = ~wake_pin_in;
      wait_n(4);
      rd(2'd2);
      chk("R7 edge flag", (rdv >> 1) & 1, 1);
      chk("R8 level in", (rdv >> 7) & 1, int'(wake_pin_in));
      chk("R10 irq edge", irq, 1);
    end
    wr(2'd2, 8'h02);
    wait_n(4);
    rd(2'd2); chk("R9 edge clear", (rdv >> 1) & 1, 0);
    chk("R10 irq idle", irq, 0);
    chk("R7 drv stays off", wake_drv_en, 0);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule